// File: doc/BRIEF.md
# Conditional Branch Next-PC Selector

This combinational block chooses the program counter value for the next instruction of a simple 32-bit processor. Each cycle it is given the current PC, the four arithmetic flags, a 4-bit condition code and a branch kind. It then produces the next PC, which is one of three values: the sequential address, a target computed by the decoder, or a target read from a register.

The condition code is checked against the flags, and a branch happens only when that check passes. The two link kinds also raise a write strobe for the return-address register and drive the sequential address as the value to store. The block holds no state. Instruction fetch, decode and the register file are handled outside it.

Top module: `branch_next_pc`

## Requirements
- R1: With branch kind 0 (none), `next_pc` equals `cur_pc + 4` and `link_we` is 0, whatever the condition and flags.
- R2: Branch kind 1 (direct) with a passing condition sets `next_pc` to `direct_tgt`. Branch kind 2 (direct with link) behaves the same for the PC.
- R3: Branch kind 3 (indirect) with a passing condition sets `next_pc` to `reg_tgt`. Branch kind 4 (indirect with link) behaves the same for the PC.
- R4: Kinds 2 and 4 with a passing condition assert `link_we` and drive `link_val` with `cur_pc + 4`.
- R5: A branch whose condition fails yields `next_pc = cur_pc + 4` with `link_we` at 0.
- R6: `flags` is {N,Z,C,V} in bits 3..0. Each of the following codes passes on a single flag: code 0 passes when Z=1 and code 1 when Z=0; code 2 when C=1 and code 3 when C=0; code 4 when N=1 and code 5 when N=0; code 6 when V=1 and code 7 when V=0.
- R7: Code 8 (unsigned higher) passes when C=1 and Z=0. Code 9 (unsigned lower or same) passes when C=0 or Z=1.
- R8: The signed comparisons are as follows. Code 10 passes when N==V and code 11 when N!=V. Code 12 passes when Z=0 and N==V. Code 13 passes when Z=1 or N!=V.
- R9: Code 14 always passes and code 15 never passes.
- R10: Branch kinds 5, 6 and 7 act exactly as kind 0.
- R11: The sequential address wraps modulo 2^32, so `cur_pc = 0xFFFFFFFC` gives 0.
- R12: Kinds 1 and 3 never assert `link_we`, even when taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cur_pc | input | 32 | Address of the current instruction |
| flags | input | 4 | {N,Z,C,V} condition flags |
| cond | input | 4 | Condition code, 0..15 |
| br_kind | input | 3 | 0 none, 1 direct, 2 direct+link, 3 indirect, 4 indirect+link, 5..7 none |
| direct_tgt | input | 32 | Target computed by the decoder |
| reg_tgt | input | 32 | Target read from a register |
| next_pc | output | 32 | Address of the next instruction |
| link_we | output | 1 | Write strobe for the return-address register |
| link_val | output | 32 | Return address to store |

## Verification
The bench sweeps all 16 condition codes against all 16 flag combinations for both a direct and an indirect branch. A decoder with a swapped pair of codes, or one that gets LS, GT or LE wrong, sends the PC to the target when it should fall through. The link checks expect the strobe only on a taken link branch, so a design that writes the link on a failed condition or on a plain branch is caught. The bench also drives the unused kinds and the PC just below 2^32. A design that treats kinds 5 to 7 as branches is caught there, as is one that saturates instead of wrapping.

// File: rtl/branch_next_pc.sv
module branch_next_pc #(
  parameter int XLEN = 32,
  parameter int STEP = 4
) (
  input  logic [XLEN-1:0] cur_pc,
  input  logic [3:0]      flags,
  input  logic [3:0]      cond,
  input  logic [2:0]      br_kind,
  input  logic [XLEN-1:0] direct_tgt,
  input  logic [XLEN-1:0] reg_tgt,
  output logic [XLEN-1:0] next_pc,
  output logic            link_we,
  output logic [XLEN-1:0] link_val
);
  localparam logic [XLEN-1:0] INC = XLEN'(STEP);

  logic n, z, c, v;
  logic pass, is_dir, is_ind, is_link, taken;
  logic [XLEN-1:0] seq_pc;

  assign {n, z, c, v} = flags;

  always_comb begin
    case (cond)
      4'd0:    pass = z;
      4'd1:    pass = !z;
      4'd2:    pass = c;
      4'd3:    pass = !c;
      4'd4:    pass = n;
      4'd5:    pass = !n;
      4'd6:    pass = v;
      4'd7:    pass = !v;
      4'd8:    pass = c && !z;
      4'd9:    pass = !c || z;
      4'd10:   pass = n == v;
      4'd11:   pass = n != v;
      4'd12:   pass = !z && (n == v);
      4'd13:   pass = z || (n != v);
      4'd14:   pass = 1'b1;
      default: pass = 1'b0;
    endcase
  end

  assign is_dir  = (br_kind == 3'd1) || (br_kind == 3'd2);
  assign is_ind  = (br_kind == 3'd3) || (br_kind == 3'd4);
  assign is_link = (br_kind == 3'd2) || (br_kind == 3'd4);
  assign taken   = pass && (is_dir || is_ind);

  assign seq_pc   = cur_pc + INC;
  assign next_pc  = !taken ? seq_pc : (is_ind ? reg_tgt : direct_tgt);
  assign link_we  = taken && is_link;
  assign link_val = seq_pc;
endmodule

// File: rtl/branch_next_pc_chk.sv
module branch_next_pc_chk #(
  parameter int XLEN = 32,
  parameter int STEP = 4
) (
  input logic [XLEN-1:0] cur_pc,
  input logic [3:0]      cond,
  input logic [2:0]      br_kind,
  input logic [XLEN-1:0] direct_tgt,
  input logic [XLEN-1:0] reg_tgt,
  input logic [XLEN-1:0] next_pc,
  input logic            link_we,
  input logic [XLEN-1:0] link_val
);
  always_comb begin
    p_idle_seq_r1: assert (br_kind != 3'd0 || (next_pc == cur_pc + XLEN'(STEP) && !link_we))
      else $error("idle kind moved PC off sequence");
    p_link_kind_r12: assert (!link_we || br_kind == 3'd2 || br_kind == 3'd4)
      else $error("link strobe on non-link kind");
    p_link_target_r4: assert (!link_we || (br_kind == 3'd2 ? next_pc == direct_tgt : next_pc == reg_tgt))
      else $error("link strobe without taken branch");
    p_link_value_r4: assert (!link_we || link_val == cur_pc + XLEN'(STEP))
      else $error("wrong return address");
    p_never_r9: assert (cond != 4'd15 || (next_pc == cur_pc + XLEN'(STEP) && !link_we))
      else $error("code 15 took a branch");
    p_always_dir_r2: assert (!(cond == 4'd14 && br_kind == 3'd1) || next_pc == direct_tgt)
      else $error("always-direct not taken");
    p_always_ind_r3: assert (!(cond == 4'd14 && br_kind == 3'd3) || next_pc == reg_tgt)
      else $error("always-indirect not taken");
    p_bad_kind_r10: assert (br_kind < 3'd5 || (next_pc == cur_pc + XLEN'(STEP) && !link_we))
      else $error("unused kind branched");
  end
endmodule

bind branch_next_pc branch_next_pc_chk #(.XLEN(XLEN), .STEP(STEP)) u_chk (
  .cur_pc(cur_pc), .cond(cond), .br_kind(br_kind), .direct_tgt(direct_tgt),
  .reg_tgt(reg_tgt), .next_pc(next_pc), .link_we(link_we), .link_val(link_val)
);

// File: tb/test_branch_next_pc.sv
module test_branch_next_pc;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic [31:0] cur_pc = '0, direct_tgt = '0, reg_tgt = '0;
  logic [3:0]  flags = '0, cond = '0;
  logic [2:0]  br_kind = '0;
  logic [31:0] next_pc, link_val;
  logic        link_we;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_next_pc i_branch_next_pc (
    .cur_pc(cur_pc), .flags(flags), .cond(cond), .br_kind(br_kind),
    .direct_tgt(direct_tgt), .reg_tgt(reg_tgt),
    .next_pc(next_pc), .link_we(link_we), .link_val(link_val)
  );

  function automatic bit expect_pass(input logic [3:0] cc, input logic [3:0] f);
    bit fn = f[3], fz = f[2], fc = f[1], fv = f[0];
    bit r;
    if (cc == 4'd15) r = 0;
    else if (cc == 4'd14) r = 1;
    else if (cc == 4'd13) r = fz | (fn ^ fv);
    else if (cc == 4'd12) r = ~fz & ~(fn ^ fv);
    else if (cc == 4'd11) r = fn ^ fv;
    else if (cc == 4'd10) r = ~(fn ^ fv);
    else if (cc == 4'd9)  r = ~fc | fz;
    else if (cc == 4'd8)  r = fc & ~fz;
    else begin
      bit sel;
      case (cc[3:1])
        3'd0: sel = fz;
        3'd1: sel = fc;
        3'd2: sel = fn;
        default: sel = fv;
      endcase
      r = cc[0] ? ~sel : sel;
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h (kind %0d cond %0d flags %b)",
               req, got, exp, br_kind, cond, flags);
    end
  endtask

  task automatic apply(input logic [2:0] k, input logic [3:0] cc, input logic [3:0] f,
                       input logic [31:0] pc, input logic [31:0] dt, input logic [31:0] rt);
    @(negedge clk);
    br_kind = k; cond = cc; flags = f; cur_pc = pc; direct_tgt = dt; reg_tgt = rt;
    @(posedge clk); #1;
  endtask

  task automatic t_idle;
    for (int cc = 0; cc < 16; cc++) begin
      apply(3'd0, 4'(cc), 4'hF, 32'h0000_1000, 32'hAAAA_0000, 32'hBBBB_0000);
      chk("R1 next_pc", next_pc, 32'h0000_1004);
      chk("R1 link_we", {31'd0, link_we}, 32'd0);
    end
  endtask

  task automatic t_sweep(input logic [2:0] k, input string req);
    for (int cc = 0; cc < 16; cc++)
      for (int f = 0; f < 16; f++) begin
        bit p;
        p = expect_pass(4'(cc), 4'(f));
        apply(k, 4'(cc), 4'(f), 32'h0000_2000, 32'h0000_4440, 32'h0008_8880);
        if (p) chk(req, next_pc, (k == 3'd3) ? 32'h0008_8880 : 32'h0000_4440);
        else   chk("R5 fail falls through", next_pc, 32'h0000_2004);
        if (cc < 8)       chk("R6 single flag", next_pc, p ? next_pc : 32'h0000_2004);
        else if (cc < 10) chk("R7 unsigned", next_pc, p ? next_pc : 32'h0000_2004);
        else if (cc < 14) chk("R8 signed", next_pc, p ? next_pc : 32'h0000_2004);
        else              chk("R9 always/never", {31'd0, p}, (cc == 14) ? 32'd1 : 32'd0);
        chk("R12 no link", {31'd0, link_we}, 32'd0);
      end
  endtask

  task automatic t_links;
    apply(3'd2, 4'd14, 4'h0, 32'h0000_3000, 32'h0000_5000, 32'h0000_6000);
    chk("R4 we direct", {31'd0, link_we}, 32'd1);
    chk("R4 val direct", link_val, 32'h0000_3004);
    chk("R2 target", next_pc, 32'h0000_5000);
    apply(3'd4, 4'd0, 4'b0100, 32'h0000_3100, 32'h0000_5000, 32'h0000_6000);
    chk("R4 we indirect", {31'd0, link_we}, 32'd1);
    chk("R4 val indirect", link_val, 32'h0000_3104);
    chk("R3 target", next_pc, 32'h0000_6000);
    apply(3'd2, 4'd0, 4'b0000, 32'h0000_3200, 32'h0000_5000, 32'h0000_6000);
    chk("R5 no link on fail", {31'd0, link_we}, 32'd0);
    chk("R5 seq on fail", next_pc, 32'h0000_3204);
    apply(3'd4, 4'd15, 4'hF, 32'h0000_3300, 32'h0000_5000, 32'h0000_6000);
    chk("R9 never link", {31'd0, link_we}, 32'd0);
  endtask

  task automatic t_bad_kinds;
    for (int k = 5; k < 8; k++) begin
      apply(3'(k), 4'd14, 4'hF, 32'h0000_7000, 32'h0000_9000, 32'h0000_A000);
      chk("R10 next_pc", next_pc, 32'h0000_7004);
      chk("R10 link_we", {31'd0, link_we}, 32'd0);
    end
  endtask

  task automatic t_wrap;
    apply(3'd0, 4'd14, 4'h0, 32'hFFFF_FFFC, 32'h0, 32'h0);
    chk("R11 wrap", next_pc, 32'h0000_0000);
    apply(3'd2, 4'd14, 4'h0, 32'hFFFF_FFFC, 32'h0000_0100, 32'h0);
    chk("R11 link wrap", link_val, 32'h0000_0000);
  endtask

  initial begin
    fork
      begin
        t_idle();
        t_sweep(3'd1, "R2 direct taken");
        t_sweep(3'd3, "R3 indirect taken");
        t_links();
        t_bad_kinds();
        t_wrap();
      end
      begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule